// File: doc/BRIEF.md
# Fixed-OR Programmable Array Logic with Pin Feedback

This block models a small programmable array logic device. The AND array can be programmed. The OR array is fixed. The array sees ten dedicated inputs and also the pin levels of the first six outputs, each in true and complemented form. Every output owns seven product terms, which are OR-ed into its sum. It also owns one more term that drives its tri-state enable. A polarity bit picks whether the pin shows the sum or its complement. The tri-state pin is modelled as a driven value plus an enable. When an output is not driven, its feedback path takes the level from an external pin-input port. Turning an enable off permanently therefore lets that pin serve as an extra input. Feeding outputs back into the array makes two-pass logic and helper terms possible.

The fuse map arrives as a serial stream under a valid/ready handshake. `fuse_ready` follows `prog_en`. A bit is taken only on a rising edge where both `fuse_valid` and `fuse_ready` are high. A sender holding `fuse_valid` high while `prog_en` is low stalls without loss, because no bit is consumed. Evaluation is purely combinational from the stored map and the input pins. The map is evaluated in unrolled passes. Any map whose feedback graph is acyclic therefore settles to its combinational result without a real loop in the logic.

Top module: `pal_fixed_or`

## Requirements
- R1: After reset every fuse is blown (stored 0). With every term true and polarity inverted, `out_en` is 8'hFF and `out_val` is 8'h00.
- R2: `fuse_ready` equals `prog_en`. A bit is stored only on a rising edge with `fuse_valid` and `fuse_ready` both high. Bits offered while `prog_en` is low leave the map, and so the outputs, unchanged.
- R3: The map holds 2056 bits, and the first bit accepted lands at map position 0 once all 2056 are in. The map is sent output 0 first. Each output uses 257 bits: its enable term (32 bits), then OR terms 1 to 7 (32 bits each), then its polarity bit. Within a term, bit 2s is the true literal of signal s and bit 2s+1 its complement. A stored 1 means the fuse is intact (literal connected).
- R4: Signals 0 to 9 are `in_pins[0..9]`. Signals 10 to 15 are the pin levels of outputs 0 to 5.
- R5: A term with no intact fuse is 1. A term with both literals of any one signal intact is 0. Otherwise a term is the AND of its connected literals.
- R6: `out_val[o]` is the complement of the OR of the seven terms of output o when its polarity bit is 0, and that OR itself when the bit is 1.
- R7: `out_en[o]` equals the enable term of output o.
- R8: The pin level of feedback output j is `out_val[j]` when `out_en[j]` is 1, else `pin_in[j]`. An output whose enable term is constant 0 acts as an input.
- R9: Under an acyclic feedback map, chains of feedback through up to six outputs settle within the same cycle as the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fuse stream |
| rst_n | input | 1 | Active-low reset, blows every fuse |
| prog_en | input | 1 | Programming window; gates `fuse_ready` |
| fuse_valid | input | 1 | A fuse bit is offered |
| fuse_bit | input | 1 | Offered fuse bit, 1 = intact |
| fuse_ready | output | 1 | Stream accepts a bit this cycle |
| in_pins | input | 10 | Dedicated array inputs |
| pin_in | input | 6 | Outside level on the pins of outputs 0 to 5 |
| out_val | output | 8 | Value each output driver presents |
| out_en | output | 8 | Tri-state enable of each output |

## Verification
A fuse bit lands in the map on the first rising edge where the handshake completes. The outputs reflect a completed map once the final accepted bit's edge has passed. The bench therefore compares outputs only after the load has finished and the stream has gone idle. Evaluation has no register, so `out_val` and `out_en` are due in the same cycle as a change on `in_pins` or `pin_in`. The bench drives them on the falling edge and samples one nanosecond later. Expected values come from a bench model that iterates the requirements to a fixed point. Directed maps build a five-output feedback chain, a pin turned into an input, and constant-one and contradictory terms.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
  localparam int PAL_N_IN  = 10;
  localparam int PAL_N_OUT = 8;
  localparam int PAL_N_FB  = 6;
  localparam int PAL_N_OR  = 7;
endpackage

// File: rtl/pal_fuse_chain.sv
`timescale 1ns/1ps
module pal_fuse_chain #(
  parameter int MAP_BITS = 2056
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_en,
  input  logic                fuse_valid,
  input  logic                fuse_bit,
  output logic                fuse_ready,
  output logic [MAP_BITS-1:0] fmap
);
  logic take;

  assign fuse_ready = prog_en;
  assign take       = fuse_valid & fuse_ready;

  // first bit accepted migrates to index 0 after MAP_BITS shifts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fmap <= '0;
    else if (take) fmap <= {fuse_bit, fmap[MAP_BITS-1:1]};
  end

  p_noprog_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> $stable(fmap)) else $error("map moved outside programming");

  p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_valid && fuse_ready) |=> (fmap[MAP_BITS-1] == $past(fuse_bit)))
    else $error("accepted bit not at head of map");
endmodule

// File: rtl/pal_term.sv
`timescale 1ns/1ps
module pal_term #(
  parameter int N_SIG = 16
) (
  input  logic [N_SIG-1:0]   sig,
  input  logic [2*N_SIG-1:0] fuses,
  output logic               hit
);
  logic [N_SIG-1:0] keep_t, keep_c, miss;

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign keep_t[s] = fuses[2*s];
    assign keep_c[s] = fuses[2*s+1];
    assign miss[s]   = (keep_t[s] & ~sig[s]) | (keep_c[s] & sig[s]);
  end

  assign hit = ~|miss;

  always_comb begin
    p_conflict_zero_r5: assert (!(|(keep_t & keep_c)) || !hit)
      else $error("term with both polarities is true");
    p_empty_one_r5: assert ((|fuses) || hit)
      else $error("term without fuses is false");
  end
endmodule

// File: rtl/pal_eval_pass.sv
`timescale 1ns/1ps
module pal_eval_pass #(
  parameter int N_IN  = 10,
  parameter int N_OUT = 8,
  parameter int N_FB  = 6,
  parameter int N_OR  = 7,
  localparam int N_SIG    = N_IN + N_FB,
  localparam int N_LIT    = 2 * N_SIG,
  localparam int BPO      = (N_OR + 1) * N_LIT + 1,
  localparam int MAP_BITS = N_OUT * BPO
) (
  input  logic [MAP_BITS-1:0] fmap,
  input  logic [N_IN-1:0]     in_pins,
  input  logic [N_FB-1:0]     fb_in,
  input  logic [N_FB-1:0]     pin_ext,
  output logic [N_OUT-1:0]    drv,
  output logic [N_OUT-1:0]    en,
  output logic [N_FB-1:0]     fb_out
);
  logic [N_SIG-1:0] sig;
  assign sig = {fb_in, in_pins};

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_OR:0] hits;
    logic          sum;
    logic          pol;
    // term 0 is the enable, terms 1..N_OR feed the fixed OR
    for (genvar t = 0; t <= N_OR; t++) begin : g_term
      pal_term #(.N_SIG(N_SIG)) u_term (
        .sig  (sig),
        .fuses(fmap[o*BPO + t*N_LIT +: N_LIT]),
        .hit  (hits[t])
      );
    end
    assign sum    = |hits[N_OR:1];
    assign pol    = fmap[o*BPO + BPO - 1];
    assign en[o]  = hits[0];
    assign drv[o] = pol ? sum : ~sum;
  end

  for (genvar j = 0; j < N_FB; j++) begin : g_fb
    assign fb_out[j] = en[j] ? drv[j] : pin_ext[j];
  end
endmodule

// File: rtl/pal_fixed_or.sv
`timescale 1ns/1ps
module pal_fixed_or
  import pal_pkg::*;
#(
  parameter int N_IN  = PAL_N_IN,
  parameter int N_OUT = PAL_N_OUT,
  parameter int N_FB  = PAL_N_FB,
  parameter int N_OR  = PAL_N_OR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             fuse_valid,
  input  logic             fuse_bit,
  output logic             fuse_ready,
  input  logic [N_IN-1:0]  in_pins,
  input  logic [N_FB-1:0]  pin_in,
  output logic [N_OUT-1:0] out_val,
  output logic [N_OUT-1:0] out_en
);
  localparam int N_SIG    = N_IN + N_FB;
  localparam int N_LIT    = 2 * N_SIG;
  localparam int BPO      = (N_OR + 1) * N_LIT + 1;
  localparam int MAP_BITS = N_OUT * BPO;
  localparam int N_PASS   = N_FB + 1;

  logic [MAP_BITS-1:0] fmap;

  pal_fuse_chain #(.MAP_BITS(MAP_BITS)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (prog_en),
    .fuse_valid(fuse_valid),
    .fuse_bit  (fuse_bit),
    .fuse_ready(fuse_ready),
    .fmap      (fmap)
  );

  logic [N_FB-1:0]  fb_lvl  [N_PASS+1];
  logic [N_OUT-1:0] drv_lvl [N_PASS];
  logic [N_OUT-1:0] en_lvl  [N_PASS];

  assign fb_lvl[0] = pin_in;

  // each pass resolves one more level of an acyclic feedback chain
  for (genvar p = 0; p < N_PASS; p++) begin : g_pass
    pal_eval_pass #(.N_IN(N_IN), .N_OUT(N_OUT), .N_FB(N_FB), .N_OR(N_OR)) u_pass (
      .fmap   (fmap),
      .in_pins(in_pins),
      .fb_in  (fb_lvl[p]),
      .pin_ext(pin_in),
      .drv    (drv_lvl[p]),
      .en     (en_lvl[p]),
      .fb_out (fb_lvl[p+1])
    );
  end

  assign out_val = drv_lvl[N_PASS-1];
  assign out_en  = en_lvl[N_PASS-1];
endmodule

// File: tb/pal_fixed_or_tb.sv
`timescale 1ns/1ps
module pal_fixed_or_tb;
  localparam int NI = 10, NO = 8, NF = 6, NT = 8;
  localparam int NLIT = 2 * (NI + NF);
  localparam int BPO = NT * NLIT + 1;
  localparam int MB = NO * BPO;

  logic clk = 0, rst_n = 0, prog_en = 0, fuse_valid = 0, fuse_bit = 0;
  logic fuse_ready;
  logic [NI-1:0] in_pins = '0;
  logic [NF-1:0] pin_in = '0;
  logic [NO-1:0] out_val, out_en;

  int total = 0, bad = 0;
  bit done = 0;
  bit fm [MB];

  always #2 clk = ~clk;

  pal_fixed_or u_dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .fuse_valid(fuse_valid),
    .fuse_bit(fuse_bit), .fuse_ready(fuse_ready), .in_pins(in_pins),
    .pin_in(pin_in), .out_val(out_val), .out_en(out_en)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic int tb_base(int o, int t);
    return o * BPO + t * NLIT;
  endfunction

  function automatic bit term_val(int o, int t, logic [15:0] sg);
    bit r = 1;
    for (int k = 0; k < NLIT; k++)
      if (fm[tb_base(o, t) + k] && ((k % 2 == 0) ? !sg[k/2] : sg[k/2])) r = 0;
    return r;
  endfunction

  function automatic void model(input logic [NI-1:0] ins, input logic [NF-1:0] pe,
                                output logic [NO-1:0] v, output logic [NO-1:0] e);
    logic [NF-1:0] fbv = pe;
    logic [15:0] sg;
    bit sum;
    v = '0; e = '0;
    for (int it = 0; it < 10; it++) begin
      sg = {fbv, ins};
      for (int o = 0; o < NO; o++) begin
        e[o] = term_val(o, 0, sg);
        sum = 0;
        for (int t = 1; t < NT; t++) sum |= term_val(o, t, sg);
        v[o] = fm[o*BPO + BPO - 1] ? sum : !sum;
      end
      for (int j = 0; j < NF; j++) fbv[j] = e[j] ? v[j] : pe[j];
    end
  endfunction

  task automatic load_map();
    int i = 0;
    while (i < MB) begin
      @(negedge clk);
      case ($urandom % 6)
        0: begin prog_en = 1; fuse_valid = 0; end
        1: begin prog_en = 0; fuse_valid = 1; fuse_bit = $urandom % 2; end
        default: begin prog_en = 1; fuse_valid = 1; fuse_bit = fm[i]; i++; end
      endcase
      #1 check("R2 ready follows prog_en", {31'd0, fuse_ready}, {31'd0, prog_en});
    end
    @(negedge clk);
    fuse_valid = 0; prog_en = 0;
  endtask

  task automatic vec(input logic [NI-1:0] a, input logic [NF-1:0] b, input string req);
    logic [NO-1:0] ev, ee;
    @(negedge clk);
    in_pins = a; pin_in = b;
    model(a, b, ev, ee);
    #1;
    check({req, " out_val"}, {24'd0, out_val}, {24'd0, ev});
    check({req, " out_en"}, {24'd0, out_en}, {24'd0, ee});
  endtask

  task automatic zero_term(int o, int t);
    fm[tb_base(o, t)] = 1; fm[tb_base(o, t) + 1] = 1;
  endtask

  task automatic lit(int o, int t, int s, bit neg);
    fm[tb_base(o, t) + 2*s + (neg ? 1 : 0)] = 1;
  endtask

  task automatic directed_map();
    foreach (fm[k]) fm[k] = 0;
    for (int o = 0; o < NO; o++)
      for (int t = 2; t < NT; t++) zero_term(o, t);
    lit(0, 1, 0, 0); lit(0, 1, 1, 1);                    // out0 = ~(in0 & ~in1)
    zero_term(1, 0); zero_term(1, 1);                    // pin1 used as input
    lit(2, 1, 11, 0); fm[2*BPO + BPO - 1] = 1;           // out2 = pin1
    lit(3, 1, 10, 0); lit(3, 1, 2, 0); fm[3*BPO + BPO - 1] = 1;
    lit(4, 0, 9, 0); lit(4, 1, 13, 0); fm[4*BPO + BPO - 1] = 1;
    lit(5, 1, 14, 0);                                    // out5 = ~pin4
    lit(6, 1, 15, 0); fm[6*BPO + BPO - 1] = 1;           // out6 = pin5
    fm[7*BPO + BPO - 1] = 1;                             // out7 term1 empty
  endtask

  task automatic random_map();
    for (int o = 0; o < NO; o++) begin
      for (int t = 0; t < NT; t++)
        for (int k = 0; k < NLIT; k++) begin
          int s = k / 2;
          bit ok = (s < NI) || ((s - NI) < o);
          fm[tb_base(o, t) + k] = ok && ($urandom % 12 == 0);
        end
      if ($urandom % 2 == 0)
        for (int k = 0; k < NLIT; k++) fm[tb_base(o, 0) + k] = 0;
      fm[o*BPO + BPO - 1] = $urandom % 2;
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset out_en", {24'd0, out_en}, 32'hFF);
    check("R1 reset out_val", {24'd0, out_val}, 32'h00);
    check("R2 reset ready", {31'd0, fuse_ready}, 32'd0);
    @(negedge clk) rst_n = 1;

    directed_map();
    load_map();
    vec(10'h205, 6'h00, "R3 R9 chain hi");
    check("R6 out0 low", {31'd0, out_val[0]}, 32'd0);
    check("R9 out6 chain", {31'd0, out_val[6]}, 32'd1);
    check("R5 empty term one", {31'd0, out_val[7]}, 32'd1);
    check("R7 enable from in9", {31'd0, out_en[4]}, 32'd1);
    vec(10'h204, 6'h02, "R4 R9 chain lo");
    check("R9 out6 chain low", {31'd0, out_val[6]}, 32'd0);
    check("R8 pin1 as input", {31'd0, out_val[2]}, 32'd1);
    check("R5 conflict enable", {31'd0, out_en[1]}, 32'd0);
    vec(10'h004, 6'h10, "R8 disabled pin4");
    check("R8 out5 from pin_in4", {31'd0, out_val[5]}, 32'd0);
    vec(10'h004, 6'h00, "R8 disabled pin4 lo");
    check("R8 out5 from pin_in4 lo", {31'd0, out_val[5]}, 32'd1);

    @(negedge clk);
    prog_en = 0; fuse_valid = 1;
    for (int c = 0; c < 30; c++) begin
      fuse_bit = $urandom % 2;
      @(negedge clk);
    end
    fuse_valid = 0;
    vec(10'h205, 6'h00, "R2 ignored stream");
    vec(10'h204, 6'h02, "R2 ignored stream b");

    for (int m = 0; m < 3; m++) begin
      random_map();
      load_map();
      for (int n = 0; n < 40; n++)
        vec(NI'($urandom), NF'($urandom), "R3 R4 R5 R6 R7 R8 R9 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule